// File: doc/BRIEF.md
# Hardware Conversion Sequencer with Channel Scanning

This block paces analog-to-digital conversions without help from software. Each conversion needs a pacing event. The event is either a one-cycle tick from an internal timer or a falling edge on an external clock pin. Pacing can be qualified in two ways: by a one-shot rising-edge trigger on a digital input, or by holding that same input high as a level gate. The block issues a one-cycle start-of-conversion pulse and presents a channel address to the analog multiplexer. It then waits for the converter's end-of-conversion strobe before it accepts another pacing event.

The channel address comes from one of two places. With scanning off, it is a fixed channel from the general control settings. With scanning on, it comes from a scan pointer that moves between a first and a last limit. The pointer counts upward when first is at or below last, and downward otherwise. It wraps back to the first limit after the last limit. A sticky interrupt flag is set either by each end of conversion or by a rising edge on the external clock pin. The host line is that flag masked by an enable.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, socPulse, trigSeen and irqOut are 0. While hwEnable is 0, no socPulse is issued. Dropping hwEnable cancels a conversion in progress, so the next allowed pacing event after re-enabling starts at once.
- R2: With useInternal=1 and no qualifier active, a paceTick high during one clock cycle makes socPulse high for exactly the following cycle.
- R3: With useInternal=0, a falling edge on extClkIn passes through a two-stage synchroniser. socPulse rises on the third rising clock edge after the pin changes. A rising edge on extClkIn starts nothing.
- R4: With trigEnable=1 and gateEnable=0, pacing events are ignored until a synchronised rising edge on digIn1. From then on, trigSeen reads 1 and conversions run. trigSeen returns to 0 one cycle after hwEnable is 0.
- R5: With trigEnable=1 and gateEnable=1, conversions run only while synchronised digIn1 is 1, and trigSeen stays 0. With gateEnable=1 alone, digIn1 has no effect.
- R6: A pacing event that arrives after a socPulse and before or during the cycle in which eocIn is sampled high is dropped. socPulse never lasts more than one cycle.
- R7: With scanEnable=1 and scanFirst<=scanLast, chanAddr holds the scan pointer during each socPulse. The pointer advances by +1 on the clock edge that ends the pulse, and goes from scanLast back to scanFirst.
- R8: With scanFirst>scanLast, the scan pointer counts down by 1 per conversion and goes from scanLast back to scanFirst.
- R9: On every 0-to-1 change of hwEnable, the scan pointer reloads from scanFirst, so the first conversion after enabling uses scanFirst.
- R10: With scanEnable=0, chanAddr equals fixedChan.
- R11: With eocSel=1, each cycle with eocIn high sets the interrupt flag on that clock edge. With eocSel=0, eocIn does not set it. Instead, a rising edge on extClkIn sets the flag on the third rising clock edge after the pin changes.
- R12: irqOut is the interrupt flag ANDed with intEnable. The flag holds until intClear is sampled high, which clears it on that edge unless a setting event occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hwEnable | input | 1 | Run hardware-paced conversions |
| useInternal | input | 1 | 1: internal tick paces, 0: external falling edge paces |
| trigEnable | input | 1 | Trigger/gate enable bit |
| gateEnable | input | 1 | Gate select bit (see R4, R5) |
| scanEnable | input | 1 | Use scan pointer as channel |
| eocSel | input | 1 | Interrupt source: 1 end of conversion, 0 external rising edge |
| intEnable | input | 1 | Interrupt mask |
| intClear | input | 1 | Clear the interrupt flag |
| fixedChan | input | 3 | Channel used when scanning is off |
| scanFirst | input | 3 | Scan start limit |
| scanLast | input | 3 | Scan end limit |
| paceTick | input | 1 | Internal pacing tick, synchronous |
| extClkIn | input | 1 | External clock pin, asynchronous |
| digIn1 | input | 1 | Trigger/gate pin, asynchronous |
| eocIn | input | 1 | End-of-conversion strobe from converter |
| socPulse | output | 1 | Start-of-conversion pulse |
| chanAddr | output | 3 | Multiplexer channel address |
| trigSeen | output | 1 | Trigger has occurred |
| irqOut | output | 1 | Host interrupt line |

## Verification
Some inputs are synchronous: a paceTick, an eocIn or an intClear acts on the next clock edge. So socPulse, the flag and irqOut are checked at the falling edge that follows that rising edge. The asynchronous pins, extClkIn and digIn1, cross two synchroniser stages and an edge register. Their effects are checked at the falling edge after the third rising edge. The intermediate falling edges are checked as well, to confirm that nothing arrives early. The scan channel is checked in the cycle where socPulse is high. The expected sequence comes from a bench function that steps from scanFirst toward scanLast and wraps.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
  // Strobes from control to datapath, all valid for one cycle.
  typedef struct packed {
    logic reload;    // hwEnable went 0 -> 1
    logic advance;   // a start pulse is on the output this cycle
    logic intEvent;  // selected interrupt source fired
  } seqStrobe_t;
endpackage

// File: rtl/convseq_sync.sv
module convseq_sync #(
  parameter int Stages = 2,
  parameter int Width  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] din,
  output logic [Width-1:0] dout
);
  logic [Width-1:0] stage [Stages];

  generate
    for (genvar i = 0; i < Stages; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage[Stages-1];
endmodule

// File: rtl/convseq_ctrl.sv
module convseq_ctrl
  import convseq_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hwEnable,
  input  logic       useInternal,
  input  logic       trigEnable,
  input  logic       gateEnable,
  input  logic       eocSel,
  input  logic       paceTick,
  input  logic       extClkIn,
  input  logic       digIn1,
  input  logic       eocIn,
  output logic       socPulse,
  output logic       trigSeen,
  output seqStrobe_t strobe
);
  localparam int PinCount = 2;

  logic [PinCount-1:0] pinRaw, pinSync;
  logic extSync, digSync, extPrev, digPrev, hwPrev, busy;
  logic extFall, extRise, digRise;
  logic trigMode, gateMode, qualOk, paceEvent, fire;

  assign pinRaw = {digIn1, extClkIn};

  convseq_sync #(.Stages(SyncStages), .Width(PinCount)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinRaw),
    .dout(pinSync)
  );

  assign extSync = pinSync[0];
  assign digSync = pinSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      digPrev <= 1'b0;
      hwPrev  <= 1'b0;
    end else begin
      extPrev <= extSync;
      digPrev <= digSync;
      hwPrev  <= hwEnable;
    end
  end

  assign extFall = extPrev & ~extSync;
  assign extRise = ~extPrev & extSync;
  assign digRise = ~digPrev & digSync;

  // Trigger only when gate bit is clear; gate when both bits set.
  assign trigMode  = trigEnable & ~gateEnable;
  assign gateMode  = trigEnable & gateEnable;
  assign qualOk    = trigMode ? trigSeen : (gateMode ? digSync : 1'b1);
  assign paceEvent = useInternal ? paceTick : extFall;
  assign fire      = hwEnable & qualOk & paceEvent & ~busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigSeen <= 1'b0;
    end else if (!hwEnable) begin
      trigSeen <= 1'b0;
    end else if (trigMode && digRise) begin
      trigSeen <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      socPulse <= 1'b0;
    end else begin
      socPulse <= fire;
      if (!hwEnable)  busy <= 1'b0;
      else if (fire)  busy <= 1'b1;
      else if (eocIn) busy <= 1'b0;
    end
  end

  assign strobe.reload   = hwEnable & ~hwPrev;
  assign strobe.advance  = socPulse;
  assign strobe.intEvent = eocSel ? eocIn : extRise;

  // R1: no start pulse follows a disabled cycle
  p_no_soc_disabled_r1: assert property (@(posedge clk) disable iff (!rstN)
    !hwEnable |=> !socPulse);
  // R6: start pulse lasts a single cycle
  p_soc_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    socPulse |=> !socPulse);
  // R4: trigger status clears when disabled
  p_trig_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    !hwEnable |=> !trigSeen);
  // R5: gate mode never reports a trigger
  p_gate_no_trig_r5: assert property (@(posedge clk) disable iff (!rstN)
    (gateMode && !trigSeen) |=> !trigSeen);
endmodule

// File: rtl/convseq_datapath.sv
module convseq_datapath
  import convseq_pkg::*;
#(
  parameter int ChanW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             scanEnable,
  input  logic [ChanW-1:0] fixedChan,
  input  logic [ChanW-1:0] scanFirst,
  input  logic [ChanW-1:0] scanLast,
  input  logic             intEnable,
  input  logic             intClear,
  output logic [ChanW-1:0] chanAddr,
  output logic             irqOut
);
  logic [ChanW-1:0] scanPtr, scanNext;
  logic             descending, irqFlag;

  assign descending = scanFirst > scanLast;

  always_comb begin
    if (scanPtr == scanLast)  scanNext = scanFirst;
    else if (descending)      scanNext = scanPtr - 1'b1;
    else                      scanNext = scanPtr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               scanPtr <= '0;
    else if (strobe.reload)  scanPtr <= scanFirst;
    else if (strobe.advance) scanPtr <= scanNext;
  end

  assign chanAddr = scanEnable ? scanPtr : fixedChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                irqFlag <= 1'b0;
    else if (strobe.intEvent) irqFlag <= 1'b1;
    else if (intClear)        irqFlag <= 1'b0;
  end

  assign irqOut = irqFlag & intEnable;

  // R9: reload takes the start limit
  p_reload_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> scanPtr == $past(scanFirst));
  // R11: a selected event leaves the flag set
  p_int_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.intEvent |=> irqFlag);
  // R12: flag is sticky until cleared
  p_int_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !intClear) |=> irqFlag);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import convseq_pkg::*;
#(
  parameter int ChanW      = 3,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwEnable,
  input  logic             useInternal,
  input  logic             trigEnable,
  input  logic             gateEnable,
  input  logic             scanEnable,
  input  logic             eocSel,
  input  logic             intEnable,
  input  logic             intClear,
  input  logic [ChanW-1:0] fixedChan,
  input  logic [ChanW-1:0] scanFirst,
  input  logic [ChanW-1:0] scanLast,
  input  logic             paceTick,
  input  logic             extClkIn,
  input  logic             digIn1,
  input  logic             eocIn,
  output logic             socPulse,
  output logic [ChanW-1:0] chanAddr,
  output logic             trigSeen,
  output logic             irqOut
);
  seqStrobe_t strobe;

  convseq_ctrl #(.SyncStages(SyncStages)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hwEnable   (hwEnable),
    .useInternal(useInternal),
    .trigEnable (trigEnable),
    .gateEnable (gateEnable),
    .eocSel     (eocSel),
    .paceTick   (paceTick),
    .extClkIn   (extClkIn),
    .digIn1     (digIn1),
    .eocIn      (eocIn),
    .socPulse   (socPulse),
    .trigSeen   (trigSeen),
    .strobe     (strobe)
  );

  convseq_datapath #(.ChanW(ChanW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .scanEnable(scanEnable),
    .fixedChan (fixedChan),
    .scanFirst (scanFirst),
    .scanLast  (scanLast),
    .intEnable (intEnable),
    .intClear  (intClear),
    .chanAddr  (chanAddr),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic hwEnable = 0, useInternal = 1, trigEnable = 0, gateEnable = 0;
  logic scanEnable = 0, eocSel = 1, intEnable = 0, intClear = 0;
  logic [2:0] fixedChan = 3'd5, scanFirst = 3'd0, scanLast = 3'd7;
  logic paceTick = 0, extClkIn = 0, digIn1 = 0, eocIn = 0;
  logic socPulse, trigSeen, irqOut;
  logic [2:0] chanAddr;
  int checks = 0, fails = 0;

  always #(ClkPeriod/2) clk = ~clk;

  conv_sequencer uut (
    .clk(clk), .rstN(rstN), .hwEnable(hwEnable), .useInternal(useInternal),
    .trigEnable(trigEnable), .gateEnable(gateEnable), .scanEnable(scanEnable),
    .eocSel(eocSel), .intEnable(intEnable), .intClear(intClear),
    .fixedChan(fixedChan), .scanFirst(scanFirst), .scanLast(scanLast),
    .paceTick(paceTick), .extClkIn(extClkIn), .digIn1(digIn1), .eocIn(eocIn),
    .socPulse(socPulse), .chanAddr(chanAddr), .trigSeen(trigSeen), .irqOut(irqOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] nextChan(input logic [2:0] cur, first, last);
    if (cur == last)   return first;
    if (first > last)  return cur - 3'd1;
    return cur + 3'd1;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One tick-paced conversion; checks the pulse and its channel.
  task automatic conv(input string req, input logic [2:0] expChan);
    paceTick = 1; cyc(1); paceTick = 0;
    chk({req, " soc"}, socPulse, 1);
    chk({req, " chan"}, chanAddr, expChan);
    cyc(1);
    chk({req, " soc width"}, socPulse, 0);
    eocIn = 1; cyc(1); eocIn = 0;
  endtask

  task automatic tickExpectNone(input string req);
    paceTick = 1; cyc(1); paceTick = 0;
    chk(req, socPulse, 0);
  endtask

  task automatic reEnable();
    hwEnable = 0; cyc(1); hwEnable = 1; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] exp;
    void'($urandom(32'd2718));
    cyc(3); rstN = 1; cyc(1);
    // R1 reset state, R10 fixed channel
    chk("R1 reset soc", socPulse, 0);
    chk("R1 reset trig", trigSeen, 0);
    chk("R1 reset irq", irqOut, 0);
    chk("R10 fixed chan", chanAddr, 5);
    tickExpectNone("R1 disabled tick");

    // R2 internal pacing with fixed channel
    hwEnable = 1; cyc(1);
    conv("R2", 3'd5);
    fixedChan = 3'd2; cyc(1);
    conv("R10", 3'd2);

    // R6 event during busy dropped
    paceTick = 1; cyc(1); paceTick = 0;
    chk("R6 first soc", socPulse, 1);
    cyc(1);
    tickExpectNone("R6 busy drop");
    paceTick = 1; eocIn = 1; cyc(1); paceTick = 0; eocIn = 0;
    chk("R6 tick with eoc dropped", socPulse, 0);
    conv("R6 after eoc", 3'd2);

    // R1 cancel in progress
    paceTick = 1; cyc(1); paceTick = 0;
    cyc(1); hwEnable = 0; cyc(1); hwEnable = 1; cyc(1);
    conv("R1 cancel busy", 3'd2);

    // R3 external pacing
    useInternal = 0; extClkIn = 1; cyc(4);
    chk("R3 rise starts nothing", socPulse, 0);
    extClkIn = 0; cyc(2);
    chk("R3 early", socPulse, 0);
    cyc(1);
    chk("R3 soc after 3 edges", socPulse, 1);
    eocIn = 1; cyc(1); eocIn = 0;
    useInternal = 1;

    // R4 trigger mode
    hwEnable = 0; trigEnable = 1; gateEnable = 0; cyc(1); hwEnable = 1; cyc(1);
    tickExpectNone("R4 armed no soc");
    chk("R4 armed status", trigSeen, 0);
    digIn1 = 1; cyc(2);
    chk("R4 trig early", trigSeen, 0);
    cyc(1);
    chk("R4 trig seen", trigSeen, 1);
    digIn1 = 0;
    conv("R4 triggered", 3'd2);
    hwEnable = 0; cyc(1);
    chk("R4 rearm", trigSeen, 0);

    // R5 gate mode
    gateEnable = 1; hwEnable = 1; cyc(4);
    tickExpectNone("R5 gate closed");
    digIn1 = 1; cyc(4);
    chk("R5 no trigger status", trigSeen, 0);
    conv("R5 gate open", 3'd2);
    digIn1 = 0; cyc(4);
    tickExpectNone("R5 gate closed again");
    trigEnable = 0; cyc(1);
    conv("R5 gate bit alone", 3'd2);
    gateEnable = 0;

    // R7/R8/R9 scanning, directed
    scanEnable = 1; scanFirst = 3'd6; scanLast = 3'd7;
    reEnable();
    conv("R9 reload", 3'd6);
    conv("R7 step", 3'd7);
    conv("R7 wrap", 3'd6);
    scanFirst = 3'd1; scanLast = 3'd0;
    reEnable();
    conv("R8 first", 3'd1);
    conv("R8 down", 3'd0);
    conv("R8 wrap", 3'd1);

    // R7/R8 random scans
    for (int it = 0; it < 30; it++) begin
      scanFirst = 3'($urandom_range(0, 7));
      scanLast  = 3'($urandom_range(0, 7));
      reEnable();
      exp = scanFirst;
      for (int k = 0; k < int'($urandom_range(2, 10)); k++) begin
        conv(scanFirst > scanLast ? "R8 rand" : "R7 rand", exp);
        exp = nextChan(exp, scanFirst, scanLast);
      end
    end

    // R11/R12 interrupts
    hwEnable = 0; intClear = 1; cyc(1); intClear = 0;
    eocSel = 1; intEnable = 0;
    eocIn = 1; cyc(1); eocIn = 0;
    chk("R12 masked", irqOut, 0);
    intEnable = 1; cyc(1);
    chk("R11 eoc sets flag", irqOut, 1);
    cyc(3);
    chk("R12 sticky", irqOut, 1);
    intClear = 1; cyc(1); intClear = 0;
    chk("R12 cleared", irqOut, 0);
    eocSel = 0;
    eocIn = 1; cyc(1); eocIn = 0;
    chk("R11 eoc ignored", irqOut, 0);
    extClkIn = 1; cyc(2);
    chk("R11 ext early", irqOut, 0);
    cyc(1);
    chk("R11 ext rise sets", irqOut, 1);
    extClkIn = 0; cyc(4);
    chk("R11 fall no clear", irqOut, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule